// File: doc/BRIEF.md
# Read-After-Write Hazard and Operand Forwarding Unit

This block sits beside the decode stage of a five-stage in-order pipeline and decides where each source operand of the decoding instruction comes from. It compares every source register number against the destination numbers held in the execute, memory and writeback stage registers, taking each stage's write enable into account. For each operand it produces a 2-bit forwarding select. The select is latched into the decode/execute register together with the operand and is applied one cycle later.

Most dependences are met by forwarding. In the next cycle a producer now in execute has its result in the EX/MEM register, and a producer now in memory has its result in the MEM/WB register. A producer in writeback needs no path, because the register file is written in the first half of the cycle and read in the second. A load in execute is the exception: its data cannot reach the next instruction in time. In that case the unit freezes fetch and decode and drives a bubble into execute. The bubble carries a cleared write enable.

Parameters set the register-number width and the number of source operands. Further parameters choose whether register 0 is hardwired and whether a late writeback bypass (select code 11) exists for register files that do not write first.

Top module: `raw_fwd_unit`

## Requirements
- R1: `raw_any` is 1 exactly when some source operand equals the destination of the execute, memory or writeback stage and that stage's write enable is 1. When `raw_any` is 0, every select is 00 and `freeze_fd` is 0.
- R2: If operand k matches a valid writer in execute, its select `fwd_sel[2k+1:2k]` is 01 (EX/MEM), even when memory or writeback also match.
- R3: If operand k has no valid match in execute but matches a valid writer in memory, its select is 10 (MEM/WB), even when writeback also matches.
- R4: With the default configuration, a match only in writeback gives select 00 (register file), and code 11 is never produced.
- R5: `freeze_fd` and `bubble_ex` are both 1 in the same cycle exactly when `ex_load` and `ex_wen` are 1 and some operand matches `ex_dst`. A matching non-load in execute, or a load-produced value that is already in memory, forwards without a stall.
- R6: Register number 0 never matches as a destination. A source of 0 always gets select 00.
- R7: A stage whose write enable is 0 (for example a bubble) never causes a match, a forward or a stall, even if its destination number equals a source.
- R8: Operands are resolved independently. Operand k is taken from `dec_src[k*REG_W +: REG_W]` (operand 0 is the first source, operand 1 the second), and its select appears at `fwd_sel[2k+1:2k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src | input | NUM_SRC*REG_W | Source register numbers of the decoding instruction, operand k at bits k*REG_W |
| ex_dst | input | REG_W | Destination register held in the execute stage |
| ex_wen | input | 1 | Register-write enable of the execute stage |
| ex_load | input | 1 | Execute stage holds a load |
| mem_dst | input | REG_W | Destination register held in the memory stage |
| mem_wen | input | 1 | Register-write enable of the memory stage |
| wb_dst | input | REG_W | Destination register held in the writeback stage |
| wb_wen | input | 1 | Register-write enable of the writeback stage |
| fwd_sel | output | NUM_SRC*2 | Per-operand forwarding select: 00 register file, 01 EX/MEM, 10 MEM/WB, 11 late writeback |
| raw_any | output | 1 | Any read-after-write match across all operands and stages |
| freeze_fd | output | 1 | Hold the fetch and decode stages this cycle |
| bubble_ex | output | 1 | Load a bubble with cleared write enable into execute |

## Verification
Immediate assertions evaluated on every input change check several relations. A valid execute writer always wins the select, a zero source is never forwarded, and a stall never occurs without a writing load in execute. Freeze and bubble always agree, and a quiet `raw_any` means all selects are 00 with no stall. Other behaviours can only be shown by bench scenarios that set up each pattern explicitly: memory beating writeback, writeback-only matches giving no bypass, write-disabled stages being ignored, and the two operands resolving to different sources in the same cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'b00,
      SRC_EXMEM   = 2'b01,
      SRC_MEMWB   = 2'b10,
      SRC_WBLATE  = 2'b11
   } src_pick_e;

   localparam int SEL_W = 2;
endpackage

// File: rtl/hzd_stage_cmp.sv
module hzd_stage_cmp #(
   parameter int REG_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] dst,
   input  logic             wen,
   output logic             hit
);
   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign hit = wen && (src == dst) && (|dst);
      end else begin : g_zero_plain
         assign hit = wen && (src == dst);
      end
   endgenerate
endmodule

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
   import hzd_pkg::*;
#(
   parameter bit WB_BYPASS = 1'b0
) (
   input  logic             hit_ex,
   input  logic             hit_mem,
   input  logic             hit_wb,
   output logic [SEL_W-1:0] sel
);
   src_pick_e pick;

   generate
      if (WB_BYPASS) begin : g_wb_path
         always_comb begin
            if (hit_ex)       pick = SRC_EXMEM;
            else if (hit_mem) pick = SRC_MEMWB;
            else if (hit_wb)  pick = SRC_WBLATE;
            else              pick = SRC_REGFILE;
         end
      end else begin : g_wb_none
         always_comb begin
            if (hit_ex)       pick = SRC_EXMEM;
            else if (hit_mem) pick = SRC_MEMWB;
            else              pick = SRC_REGFILE;
         end
         always_comb begin
            if (!$isunknown({hit_ex, hit_mem, hit_wb})) begin
               p_no_late_code_r4: assert (pick != SRC_WBLATE)
                  else $error("late writeback code without bypass path");
            end
         end
      end
   endgenerate

   assign sel = pick;
endmodule

// File: rtl/hzd_load_guard.sv
module hzd_load_guard #(
   parameter int NUM_SRC = 2
) (
   input  logic [NUM_SRC-1:0] hit_ex,
   input  logic               ex_load,
   output logic               stall
);
   assign stall = ex_load && (|hit_ex);
endmodule

// File: rtl/raw_fwd_unit.sv
module raw_fwd_unit
   import hzd_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter int NUM_SRC   = 2,
   parameter bit ZERO_HARD = 1'b1,
   parameter bit WB_BYPASS = 1'b0
) (
   input  logic [NUM_SRC*REG_W-1:0] dec_src,
   input  logic [REG_W-1:0]         ex_dst,
   input  logic                     ex_wen,
   input  logic                     ex_load,
   input  logic [REG_W-1:0]         mem_dst,
   input  logic                     mem_wen,
   input  logic [REG_W-1:0]         wb_dst,
   input  logic                     wb_wen,
   output logic [NUM_SRC*SEL_W-1:0] fwd_sel,
   output logic                     raw_any,
   output logic                     freeze_fd,
   output logic                     bubble_ex
);
   localparam int HIT_W = NUM_SRC * 3;

   generate
      if (REG_W < 1 || NUM_SRC < 1) begin : g_bad_cfg
         initial $fatal(1, "raw_fwd_unit: REG_W and NUM_SRC must be at least 1");
      end
   endgenerate

   logic [NUM_SRC-1:0] hit_ex, hit_mem, hit_wb;
   logic               stall;

   genvar k;
   generate
      for (k = 0; k < NUM_SRC; k++) begin : g_op
         logic [REG_W-1:0] src;
         assign src = dec_src[k*REG_W +: REG_W];

         hzd_stage_cmp #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_cmp_ex (
            .src(src), .dst(ex_dst), .wen(ex_wen), .hit(hit_ex[k]));
         hzd_stage_cmp #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_cmp_mem (
            .src(src), .dst(mem_dst), .wen(mem_wen), .hit(hit_mem[k]));
         hzd_stage_cmp #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_cmp_wb (
            .src(src), .dst(wb_dst), .wen(wb_wen), .hit(hit_wb[k]));

         hzd_fwd_pick #(.WB_BYPASS(WB_BYPASS)) u_pick (
            .hit_ex(hit_ex[k]), .hit_mem(hit_mem[k]), .hit_wb(hit_wb[k]),
            .sel(fwd_sel[k*SEL_W +: SEL_W]));

         // Per-operand checks relating the ports directly
         always_comb begin
            if (!$isunknown({src, ex_dst, ex_wen, mem_dst, mem_wen, wb_dst, wb_wen})) begin
               p_ex_wins_r2: assert (!(ex_wen && src == ex_dst && (!ZERO_HARD || ex_dst != '0))
                                     || fwd_sel[k*SEL_W +: SEL_W] == 2'b01)
                  else $error("execute writer did not win the select");
               p_zero_src_r6: assert (!ZERO_HARD || src != '0
                                      || fwd_sel[k*SEL_W +: SEL_W] == 2'b00)
                  else $error("register 0 was forwarded");
               p_idle_stages_r7: assert (ex_wen || mem_wen || (WB_BYPASS && wb_wen)
                                         || fwd_sel[k*SEL_W +: SEL_W] == 2'b00)
                  else $error("forward with no enabled writer");
            end
         end
      end
   endgenerate

   hzd_load_guard #(.NUM_SRC(NUM_SRC)) u_guard (
      .hit_ex(hit_ex), .ex_load(ex_load), .stall(stall));

   logic [HIT_W-1:0] all_hits;
   assign all_hits  = {hit_wb, hit_mem, hit_ex};
   assign raw_any   = |all_hits;
   assign freeze_fd = stall;
   assign bubble_ex = stall;

   always_comb begin
      if (!$isunknown({dec_src, ex_dst, ex_wen, ex_load, mem_dst, mem_wen, wb_dst, wb_wen})) begin
         p_stall_needs_load_r5: assert (!freeze_fd || (ex_load && ex_wen))
            else $error("stall without a writing load in execute");
         p_freeze_bubble_pair_r5: assert (freeze_fd == bubble_ex)
            else $error("freeze and bubble disagree");
         p_quiet_r1: assert (raw_any || (fwd_sel == '0 && !freeze_fd))
            else $error("action taken with no hazard");
      end
   end
endmodule

// File: tb/raw_fwd_unit_tb_top.sv
module raw_fwd_unit_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 5;

   typedef struct {
      logic [1:0] sel_a;
      logic [1:0] sel_b;
      logic       raw;
      logic       stall;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [2*RW-1:0] dec_src;
   logic [RW-1:0]   ex_dst, mem_dst, wb_dst;
   logic            ex_wen, ex_load, mem_wen, wb_wen;
   logic [3:0]      fwd_sel;
   logic            raw_any, freeze_fd, bubble_ex;

   raw_fwd_unit dut_i (
      .dec_src(dec_src), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_load(ex_load),
      .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst), .wb_wen(wb_wen),
      .fwd_sel(fwd_sel), .raw_any(raw_any), .freeze_fd(freeze_fd), .bubble_ex(bubble_ex));

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 1'b0;

   // Reference behaviour written from the requirements
   function automatic logic [1:0] want_sel(logic [RW-1:0] s,
         logic [RW-1:0] e, logic ew, logic [RW-1:0] m, logic mw);
      if (s == 0)            return 2'b00;  // R6
      if (ew && e == s)      return 2'b01;  // R2
      if (mw && m == s)      return 2'b10;  // R3
      return 2'b00;                         // R4
   endfunction

   task automatic apply(input logic [RW-1:0] a, input logic [RW-1:0] b,
         input logic [RW-1:0] e, input logic ew, input logic el,
         input logic [RW-1:0] m, input logic mw,
         input logic [RW-1:0] w, input logic ww, input string tag);
      exp_t x;
      logic ha, hb;
      @(posedge clk);
      #1;
      dec_src = {b, a}; ex_dst = e; ex_wen = ew; ex_load = el;
      mem_dst = m; mem_wen = mw; wb_dst = w; wb_wen = ww;
      x.sel_a = want_sel(a, e, ew, m, mw);
      x.sel_b = want_sel(b, e, ew, m, mw);
      ha = (a != 0) && ((ew && e == a) || (mw && m == a) || (ww && w == a));
      hb = (b != 0) && ((ew && e == b) || (mw && m == b) || (ww && w == b));
      x.raw   = ha | hb;
      x.stall = el && ew && e != 0 && (e == a || e == b);
      x.tag   = tag;
      exp_q.push_back(x);
   endtask

   // Monitor: compares away from the driving edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t x;
         x = exp_q.pop_front();
         n_tests++;
         if (fwd_sel !== {x.sel_b, x.sel_a} || raw_any !== x.raw ||
             freeze_fd !== x.stall || bubble_ex !== x.stall) begin
            n_fail++;
            $display("FAIL %s: got sel=%b raw=%b frz=%b bub=%b exp sel=%b raw=%b frz=%b bub=%b",
                     x.tag, fwd_sel, raw_any, freeze_fd, bubble_ex,
                     {x.sel_b, x.sel_a}, x.raw, x.stall, x.stall);
         end
      end
   end

   initial begin
      dec_src = '0; ex_dst = '0; ex_wen = 0; ex_load = 0;
      mem_dst = '0; mem_wen = 0; wb_dst = '0; wb_wen = 0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      //     a   b   ex  ew el mem mw wb  ww
      apply(0,  0,  0,  0, 0, 0,  0, 0,  0, "R1 idle quiet");
      apply(3,  1,  3,  1, 0, 0,  0, 0,  0, "R2 ex forward");
      apply(1,  7,  0,  0, 0, 7,  1, 0,  0, "R3 mem forward");
      apply(4,  2,  4,  1, 0, 4,  1, 4,  1, "R2 ex beats mem and wb");
      apply(9,  2,  0,  0, 0, 0,  0, 9,  1, "R4 wb only no bypass");
      apply(9,  2,  0,  0, 0, 9,  1, 9,  1, "R3 mem beats wb");
      apply(1,  5,  5,  1, 1, 0,  0, 0,  0, "R5 load use stall");
      apply(1,  2,  6,  1, 1, 0,  0, 0,  0, "R5 load no use");
      apply(8,  2,  3,  1, 1, 8,  1, 0,  0, "R5 loaded value in mem forwards");
      apply(0,  0,  0,  1, 1, 0,  1, 0,  1, "R6 register zero");
      apply(3,  3,  3,  0, 1, 3,  0, 3,  0, "R7 write disabled stages");
      apply(2,  11, 2,  1, 0, 11, 1, 0,  0, "R8 operands differ");
      apply(12, 12, 12, 1, 0, 0,  0, 0,  0, "R8 both operands same");
      apply(31, 1,  31, 1, 0, 0,  0, 0,  0, "R2 top register number");
      apply(5,  6,  6,  1, 0, 0,  0, 0,  0, "R5 non-load match no stall");
      apply(0,  0,  0,  0, 0, 0,  0, 0,  0, "R1 back to quiet");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule